// File: doc/BRIEF.md
# Two-Dimensional Deinterleaving Write Address Generator

This block produces memory write addresses for a DMA channel that takes in a stereo sample stream with the two channels alternating. It stores the samples so that one channel fills the first half of a buffer and the other channel fills the second half. A row is a short run of elements, one per channel, with a positive inner stride between them. At the end of each row a signed outer stride takes the address back to the first half and moves it on by one element. Repeating this over all rows places every left sample in the lower half and every right sample in the upper half.

The descriptors are held in a small table that the block reads through a flat input vector. Each entry gives a base address, an inner count and stride, an outer count and stride, and a link to the next entry. A start command names the first entry. Words come in over a valid/ready handshake, and each accepted word leaves the block in the same cycle as a write strobe with its address. When a descriptor runs out, the block pulses a done flag, sets that entry's processed bit, and then either loads the linked entry or stops at a null link.

Top module: `deint_agen`

## Requirements
- R1: While reset is high and in the first cycle after it, in_ready_o, done_o and busy_o are 0, and proc_flags_o and elem_cnt_o are 0.
- R2: A start_i sampled while idle selects the table entry start_idx_i. The block spends one cycle loading that entry, so in_ready_o and busy_o are high from the second cycle after the start. Entry i sits at dsc_tab_i[i*101 +: 101], with fields from MSB to LSB: base[32], inner count[16], inner stride[16], outer count[16], outer stride[16], link valid[1], link index[4].
- R3: Every accepted word (in_valid_i and in_ready_o both high) gives wr_en_o high in the same cycle, with wr_data_o equal to in_data_i and wr_addr_o equal to the current address. The first address of a descriptor is its base.
- R4: After an element that is not the last of its row, the address advances by the inner stride. After the last element of a row it advances by the outer stride instead. A descriptor covers inner count × outer count elements, and both counts must be at least 1.
- R5: With inner count 2, inner stride 512, outer count 128 and outer stride −508, the k-th word of a descriptor (k from 0) is written to base + (k mod 2)·512 + (k div 2)·4.
- R6: Strides are 16-bit two's complement values, sign-extended to 32 bits. Address arithmetic wraps modulo 2^32.
- R7: In the cycle after the last element of a descriptor is accepted, done_o is high for exactly one cycle, with done_idx_o giving the entry index and elem_cnt_o equal to inner count × outer count. From that cycle on, the entry's bit in proc_flags_o stays set until the next start.
- R8: elem_cnt_o is 0 after a descriptor is loaded and goes up by one for each accepted word.
- R9: If the finished entry has a valid link, in_ready_o is low only in the done cycle while the linked entry loads. If the link is null, the block goes idle and in_ready_o stays low, with no writes, until a new start.
- R10: start_i has no effect while the block is busy. An accepted start clears proc_flags_o.
- R11: A cycle with in_ready_o high and in_valid_i low produces no write and leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a descriptor chain (only acted on while idle) |
| start_idx_i | input | 4 | Table index of the first descriptor |
| dsc_tab_i | input | NUM_DESC*101 | Flat descriptor table |
| in_valid_i | input | 1 | Incoming sample is valid |
| in_data_i | input | 32 | Incoming sample |
| in_ready_o | output | 1 | Block accepts a sample this cycle |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 32 | Byte address of the write |
| wr_data_o | output | 32 | Write data |
| done_o | output | 1 | One-cycle pulse at the end of a descriptor |
| done_idx_o | output | 4 | Index of the descriptor that finished |
| busy_o | output | 1 | A chain is being loaded or walked |
| elem_cnt_o | output | 32 | Elements processed in the current descriptor |
| proc_flags_o | output | NUM_DESC | Processed flag for each table entry |

## Verification
The assertions check these rules on every cycle. Two consecutive writes within one descriptor always differ by one of its two sign-extended strides. done_o lasts a single cycle, keeps ready low, and comes with a count equal to the descriptor's element total. A stalled cycle keeps the address where it was. A start that arrives in a busy, stalled cycle leaves the block ready. Whether the right stride is chosen at each row boundary, how the two halves of the buffer split out, how chains follow their links to a null end, and how addresses wrap near the top of the address space can only be shown by the bench scenarios. The bench compares each write against an independent walk of the descriptor table.

// File: rtl/deint_pkg.sv
package deint_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int STR_W  = 16;
    localparam int LINK_W = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  xcnt;
        logic [STR_W-1:0]  xmod;
        logic [CNT_W-1:0]  ycnt;
        logic [STR_W-1:0]  ymod;
        logic              link_vld;
        logic [LINK_W-1:0] link_idx;
    } dsc_t;

    localparam int DSC_W = $bits(dsc_t);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  xpos;
        logic [CNT_W-1:0]  ypos;
    } walk_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN} st_e;

    function automatic logic [ADDR_W-1:0] sext(input logic [STR_W-1:0] s);
        return {{(ADDR_W-STR_W){s[STR_W-1]}}, s};
    endfunction
endpackage

// File: rtl/deint_dsc_sel.sv
module deint_dsc_sel
    import deint_pkg::*;
#(
    parameter int NUM_DESC = 4
) (
    input  logic [NUM_DESC*DSC_W-1:0] tab,
    input  logic [LINK_W-1:0]         idx,
    output dsc_t                      dsc
);
    dsc_t ent [NUM_DESC];

    for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
        assign ent[g] = tab[g*DSC_W +: DSC_W];
    end

    always_comb begin
        dsc = '0;
        for (int i = 0; i < NUM_DESC; i++) begin
            if (idx == LINK_W'(i)) dsc = ent[i];
        end
    end
endmodule

// File: rtl/deint_walk.sv
module deint_walk
    import deint_pkg::*;
(
    input  dsc_t  dsc,
    input  walk_t cur,
    output walk_t nxt,
    output logic  last
);
    logic row_end, blk_end;

    always_comb begin
        row_end = (cur.xpos == dsc.xcnt - CNT_W'(1));
        blk_end = (cur.ypos == dsc.ycnt - CNT_W'(1));
        last    = row_end && blk_end;
        nxt     = cur;
        if (!row_end) begin
            nxt.addr = cur.addr + sext(dsc.xmod);
            nxt.xpos = cur.xpos + CNT_W'(1);
        end else begin
            nxt.xpos = '0;
            nxt.addr = cur.addr + sext(dsc.ymod);
            nxt.ypos = blk_end ? '0 : cur.ypos + CNT_W'(1);
        end
    end
endmodule

// File: rtl/deint_agen.sv
module deint_agen
    import deint_pkg::*;
#(
    parameter int NUM_DESC = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [LINK_W-1:0]         start_idx_i,
    input  logic [NUM_DESC*DSC_W-1:0] dsc_tab_i,
    input  logic                      in_valid_i,
    input  logic [DATA_W-1:0]         in_data_i,
    output logic                      in_ready_o,
    output logic                      wr_en_o,
    output logic [ADDR_W-1:0]         wr_addr_o,
    output logic [DATA_W-1:0]         wr_data_o,
    output logic                      done_o,
    output logic [LINK_W-1:0]         done_idx_o,
    output logic                      busy_o,
    output logic [2*CNT_W-1:0]        elem_cnt_o,
    output logic [NUM_DESC-1:0]       proc_flags_o
);
    localparam int ECNT_W = 2 * CNT_W;

    st_e               st;
    logic [LINK_W-1:0] idx;
    dsc_t              cur_dsc;
    dsc_t              tab_dsc;
    walk_t             walk, walk_nxt;
    logic              blk_last;
    logic              hs;
    logic [ECNT_W-1:0] cnt;
    logic              done_q;
    logic [LINK_W-1:0] done_idx_q;
    logic [NUM_DESC-1:0] flags;

    deint_dsc_sel #(.NUM_DESC(NUM_DESC)) u_sel (
        .tab (dsc_tab_i),
        .idx (idx),
        .dsc (tab_dsc)
    );

    deint_walk u_walk (
        .dsc  (cur_dsc),
        .cur  (walk),
        .nxt  (walk_nxt),
        .last (blk_last)
    );

    assign in_ready_o   = (st == ST_RUN);
    assign hs           = in_valid_i && in_ready_o;
    assign wr_en_o      = hs;
    assign wr_addr_o    = walk.addr;
    assign wr_data_o    = in_data_i;
    assign done_o       = done_q;
    assign done_idx_o   = done_idx_q;
    assign busy_o       = (st != ST_IDLE);
    assign elem_cnt_o   = cnt;
    assign proc_flags_o = flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            idx        <= '0;
            cur_dsc    <= '0;
            walk       <= '0;
            cnt        <= '0;
            done_q     <= 1'b0;
            done_idx_q <= '0;
            flags      <= '0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        idx   <= start_idx_i;
                        flags <= '0;
                        st    <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    cur_dsc <= tab_dsc;
                    walk    <= '{addr: tab_dsc.base, xpos: '0, ypos: '0};
                    cnt     <= '0;
                    st      <= ST_RUN;
                end
                ST_RUN: begin
                    if (hs) begin
                        walk <= walk_nxt;
                        cnt  <= cnt + ECNT_W'(1);
                        if (blk_last) begin
                            done_q     <= 1'b1;
                            done_idx_q <= idx;
                            for (int i = 0; i < NUM_DESC; i++) begin
                                if (idx == LINK_W'(i)) flags[i] <= 1'b1;
                            end
                            if (cur_dsc.link_vld) begin
                                idx <= cur_dsc.link_idx;
                                st  <= ST_LOAD;
                            end else begin
                                st  <= ST_IDLE;
                            end
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/deint_agen_chk.sv
module deint_agen_chk
    import deint_pkg::*;
#(
    parameter int NUM_DESC = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic                 in_valid_i,
    input logic                 in_ready_o,
    input logic                 wr_en_o,
    input logic [ADDR_W-1:0]    wr_addr_o,
    input logic                 done_o,
    input logic                 busy_o,
    input logic [2*CNT_W-1:0]   elem_cnt_o,
    input logic [NUM_DESC-1:0]  proc_flags_o,
    input dsc_t                 cur_dsc
);
    logic              rst_d = 1'b0;
    logic              have_prev;
    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] diff;
    logic [2*CNT_W-1:0] total;

    assign diff  = wr_addr_o - prev_addr;
    assign total = {{CNT_W{1'b0}}, cur_dsc.xcnt} * {{CNT_W{1'b0}}, cur_dsc.ycnt};

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst_d) begin
            assert_reset_quiet_R1: assert (!in_ready_o && !done_o && !busy_o &&
                                           proc_flags_o == '0 && elem_cnt_o == '0)
                else $error("R1 outputs not quiet after reset");
        end
        if (rst) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (done_o) begin
            have_prev <= 1'b0;
        end else if (wr_en_o) begin
            have_prev <= 1'b1;
            prev_addr <= wr_addr_o;
        end
    end

    assert_stride_step_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en_o && have_prev) |-> (diff == sext(cur_dsc.xmod) || diff == sext(cur_dsc.ymod)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_count_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (elem_cnt_o == total));

    assert_done_gap_R9: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !in_ready_o);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (in_ready_o && !in_valid_i) |=> (in_ready_o && $stable(wr_addr_o)));

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (in_ready_o && !in_valid_i && start_i) |=> in_ready_o);
endmodule

bind deint_agen deint_agen_chk #(.NUM_DESC(NUM_DESC)) u_chk (.*);

// File: tb/sim_deint_agen.sv
module sim_deint_agen;
    import deint_pkg::*;

    localparam int ND = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [3:0]        start_idx_i = '0;
    logic [ND*DSC_W-1:0] dsc_tab_i;
    logic              in_valid_i = 1'b0;
    logic [31:0]       in_data_i = '0;
    logic              in_ready_o, wr_en_o, done_o, busy_o;
    logic [31:0]       wr_addr_o, wr_data_o, elem_cnt_o;
    logic [3:0]        done_idx_o;
    logic [ND-1:0]     proc_flags_o;

    dsc_t tab [ND];

    always_comb begin
        for (int i = 0; i < ND; i++) dsc_tab_i[i*DSC_W +: DSC_W] = tab[i];
    end

    deint_agen #(.NUM_DESC(ND)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .start_idx_i(start_idx_i),
        .dsc_tab_i(dsc_tab_i), .in_valid_i(in_valid_i), .in_data_i(in_data_i),
        .in_ready_o(in_ready_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .done_o(done_o), .done_idx_o(done_idx_o),
        .busy_o(busy_o), .elem_cnt_o(elem_cnt_o), .proc_flags_o(proc_flags_o)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ext16(input logic [15:0] s);
        ext16 = {{16{s[15]}}, s};
    endfunction

    // bench model
    typedef enum int {M_IDLE, M_LOAD, M_RUN} mst_e;
    mst_e        m_st = M_IDLE;
    logic [3:0]  m_idx = '0;
    dsc_t        m_d = '0;
    logic [31:0] m_addr = '0;
    int          m_x = 0, m_y = 0;
    logic [31:0] m_cnt = '0;
    logic        m_done = 1'b0;
    logic [3:0]  m_done_idx = '0;
    logic [ND-1:0] m_flags = '0;
    logic        dflt = 1'b0;

    task automatic step(input logic st_in, input logic [3:0] sidx, input int pct);
        logic hs;
        start_i     = st_in;
        start_idx_i = sidx;
        in_valid_i  = (($urandom % 100) < pct);
        in_data_i   = $urandom;
        #1;
        chk("R2 busy", {31'b0, busy_o}, {31'b0, m_st != M_IDLE});
        chk("R9 ready", {31'b0, in_ready_o}, {31'b0, m_st == M_RUN});
        chk("R7 done", {31'b0, done_o}, {31'b0, m_done});
        if (m_done) chk("R7 done index", {28'b0, done_idx_o}, {28'b0, m_done_idx});
        chk("R8 element count", elem_cnt_o, m_cnt);
        chk("R7 R10 flags", {28'b0, proc_flags_o}, {28'b0, m_flags});
        hs = in_valid_i && (m_st == M_RUN);
        chk("R3 R11 write strobe", {31'b0, wr_en_o}, {31'b0, hs});
        if (hs) begin
            chk("R4 R6 address", wr_addr_o, m_addr);
            chk("R3 data", wr_data_o, in_data_i);
            if (dflt)
                chk("R5 split address", wr_addr_o,
                    m_d.base + (m_cnt % 2) * 32'd512 + (m_cnt / 2) * 32'd4);
        end
        m_done = 1'b0;
        case (m_st)
            M_IDLE: if (st_in) begin m_idx = sidx; m_flags = '0; m_st = M_LOAD; end
            M_LOAD: begin
                m_d = tab[m_idx]; m_addr = m_d.base; m_x = 0; m_y = 0; m_cnt = '0;
                m_st = M_RUN;
            end
            default: if (hs) begin
                m_cnt++;
                if (m_x != int'(m_d.xcnt) - 1) begin
                    m_addr += ext16(m_d.xmod); m_x++;
                end else begin
                    m_x = 0;
                    m_addr += ext16(m_d.ymod);
                    if (m_y != int'(m_d.ycnt) - 1) m_y++;
                    else begin
                        m_y = 0; m_done = 1'b1; m_done_idx = m_idx; m_flags[m_idx] = 1'b1;
                        if (m_d.link_vld) begin m_idx = m_d.link_idx; m_st = M_LOAD; end
                        else m_st = M_IDLE;
                    end
                end
            end
        endcase
        @(negedge clk);
    endtask

    task automatic run_chain(input logic [3:0] sidx, input int pct, input int poke_at);
        int guard = 0;
        step(1'b1, sidx, pct);
        while (m_st != M_IDLE && guard < 5000) begin
            guard++;
            if (guard == poke_at) step(1'b1, 4'd3, 0);   // R10 start while busy
            else step(1'b0, 4'd0, pct);
        end
        for (int k = 0; k < 3; k++) step(1'b0, 4'd0, 100); // R9 idle after null link
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int seed_v;
        seed_v = int'($urandom(32'd7391));
        for (int i = 0; i < ND; i++) tab[i] = '0;
        repeat (3) @(negedge clk);
        // R1 during reset
        chk("R1 ready", {31'b0, in_ready_o}, 32'd0);
        chk("R1 done", {31'b0, done_o}, 32'd0);
        chk("R1 busy", {31'b0, busy_o}, 32'd0);
        chk("R1 flags", {28'b0, proc_flags_o}, 32'd0);
        chk("R1 count", elem_cnt_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // directed: stereo split chain 0 -> 1 -> 2 -> null
        for (int i = 0; i < 3; i++) begin
            tab[i] = '{base: 32'h1000_0000 + i * 32'h400, xcnt: 16'd2, xmod: 16'd512,
                       ycnt: 16'd128, ymod: 16'hFE04, link_vld: (i < 2),
                       link_idx: 4'(i + 1)};
        end
        tab[3] = '{base: 32'h2000_0000, xcnt: 16'd1, xmod: 16'd4, ycnt: 16'd2,
                   ymod: 16'd4, link_vld: 1'b0, link_idx: 4'd0};
        dflt = 1'b1;
        run_chain(4'd0, 100, 60);
        run_chain(4'd1, 60, 300);
        dflt = 1'b0;

        // directed: wrap across the top of the address space, negative inner stride
        tab[0] = '{base: 32'hFFFF_FFF8, xcnt: 16'd3, xmod: 16'd4, ycnt: 16'd3,
                   ymod: 16'hFFF8, link_vld: 1'b1, link_idx: 4'd1};
        tab[1] = '{base: 32'h0000_0010, xcnt: 16'd2, xmod: 16'hFFF0, ycnt: 16'd1,
                   ymod: 16'h7FFF, link_vld: 1'b0, link_idx: 4'd0};
        run_chain(4'd0, 80, 5);

        // constrained random chains
        for (int it = 0; it < 40; it++) begin
            for (int i = 0; i < ND; i++) begin
                tab[i].base     = (($urandom % 4) == 0) ? 32'hFFFF_FFF0 : $urandom;
                tab[i].xcnt     = 16'(1 + $urandom % 4);
                tab[i].ycnt     = 16'(1 + $urandom % 5);
                tab[i].xmod     = 16'($urandom);
                tab[i].ymod     = 16'($urandom);
                tab[i].link_vld = (i < ND - 1) && (($urandom % 3) != 0);
                tab[i].link_idx = 4'(i + 1);
            end
            run_chain(4'($urandom % ND), 40 + int'($urandom % 61), int'($urandom % 20));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule